// File: doc/BRIEF.md
# ADC Control and Status Register Block

This block is the processor-facing register front end of an analog-to-digital converter. It decodes a small 8-bit bus and holds a control/status byte with three parts: a 5-bit channel selector, an enable for back-to-back conversion, and an enable for the interrupt line. The status part is a read-only completion flag. The block also holds a result byte that the processor reads at the next address.

Writing the control byte starts a conversion on the selected channel, unless the selector holds the all-ones "off" code. The block drives a one-cycle start pulse and the channel number to an abstract converter. It accepts a one-cycle done pulse that carries the result. On each completion the block latches the result. It then raises the interrupt line when interrupts are enabled, or sets the completion flag when they are not. In repeat mode it restarts on its own. In single mode it waits for the next control write.

The converter side has no back-pressure: the result is always taken in the cycle the done pulse arrives, so there is no valid/ready pair there. The bus and the interrupt are plain pins.

Top module: `adc_ctrl_regs`

## Requirements
- R1: After reset the control byte at address 0x3C reads 0x1F: flag, interrupt enable and repeat bit are 0, and the channel is 31. The result byte at 0x3D reads 0x00, and `irq` and `conv_start` are low.
- R2: A write to 0x3C stores bits 6 (interrupt enable), 5 (repeat) and 4:0 (channel). Bit 7 of the written data is ignored, and the readback value of bit 7 is the completion flag.
- R3: A control write with channel below 31 makes `conv_start` high for one cycle, in the cycle after the write, with `conv_chan` equal to the new channel. A write with channel 31 issues no start and ends any conversion in progress.
- R4: A done pulse during an active conversion loads `conv_result` into the result byte. The new value is readable at 0x3D from the next cycle.
- R5: With interrupts disabled, each accepted completion sets the flag (bit 7 at 0x3C). The flag stays set until a read strobe at 0x3D, and `irq` stays low.
- R6: With interrupts enabled, bit 7 at 0x3C always reads 0, and each accepted completion raises `irq`.
- R7: `irq` is cleared by a read strobe at 0x3D or by any write to 0x3C.
- R8: In repeat mode, each accepted completion is followed in the next cycle by a new start pulse on the same channel.
- R9: In single mode, after a completion no further start is issued until the next control write.
- R10: A done pulse in the same cycle as a control write is discarded: the result byte, the flag and `irq` are unchanged. The write's own start still follows.
- R11: A done pulse while no conversion is active has no effect.
- R12: When a completion and a read strobe at 0x3D fall in the same cycle, the completion wins, so the flag or `irq` ends up set.
- R13: Any other address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the flag and the interrupt at 0x3D) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 5 | Selected channel |
| conv_done | input | 1 | One-cycle completion pulse |
| conv_result | input | 8 | Result, valid with conv_done |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions are the subtle cases. The first is a completion landing in the same cycle as a result read, where the new result must leave the flag or interrupt set. The second is a completion landing in the same cycle as a control write, where the result must be dropped and a fresh start issued. The bench drives each collision by holding `conv_done` in the exact cycle of the bus strobe. A behavioural model, which orders the clear before the set and lets the write override everything, judges the readback, `irq` and the start pulse on every clock after that edge.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int CH_W   = 5;
  localparam logic [ADDR_W-1:0] CTL_ADDR = 8'h3C;
  localparam logic [ADDR_W-1:0] RES_ADDR = 8'h3D;
  // control byte field positions
  localparam int BIT_FLAG = 7;
  localparam int BIT_IEN  = 6;
  localparam int BIT_REP  = 5;
  localparam logic [CH_W-1:0] CH_OFF = {CH_W{1'b1}};

  typedef struct packed {
    logic            ien;
    logic            rep;
    logic [CH_W-1:0] chan;
  } ctl_t;
endpackage

// File: rtl/adc_bus_decode.sv
module adc_bus_decode
  import adc_ctrl_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTL_A = CTL_ADDR,
  parameter logic [ADDR_W-1:0] RES_A = RES_ADDR
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              ctl_wr,
  output logic              res_rd,
  output logic              hit_ctl,
  output logic              hit_res
);
  always_comb begin
    hit_ctl = (addr == CTL_A);
    hit_res = (addr == RES_A);
    ctl_wr  = wr & hit_ctl;
    res_rd  = rd & hit_res;
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_wr,
  input  logic [CH_W-1:0] new_chan,
  input  logic            rep_mode,
  input  logic            conv_done,
  output logic            busy,
  output logic            start,
  output logic            done_acc
);
  logic want_run;

  always_comb begin
    want_run = (new_chan != CH_OFF);
    done_acc = conv_done & busy & ~ctl_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      start <= 1'b0;
    end else begin
      start <= 1'b0;
      if (ctl_wr) begin
        busy  <= want_run;
        start <= want_run;
      end else if (done_acc) begin
        if (rep_mode) start <= 1'b1;
        else          busy  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_flag_unit.sv
module adc_flag_unit
  import adc_ctrl_pkg::*;
#(
  parameter int RW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_acc,
  input  logic [RW-1:0] result,
  input  logic          res_rd,
  input  logic          ctl_wr,
  input  logic          ien,
  output logic          flag_q,
  output logic          irq_q,
  output logic [RW-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      data_q <= '0;
    end else begin
      // clear first, the set below takes priority
      if (res_rd) begin
        flag_q <= 1'b0;
        irq_q  <= 1'b0;
      end
      if (ctl_wr) irq_q <= 1'b0;
      if (done_acc) begin
        data_q <= result;
        if (ien) irq_q  <= 1'b1;
        else     flag_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_result,
  output logic              irq
);
  logic ctl_wr, res_rd, hit_ctl, hit_res;
  logic busy, done_acc, flag_q, irq_q;
  logic [DATA_W-1:0] data_q;
  ctl_t ctl_q, ctl_d;
  logic unused_wbit;

  assign unused_wbit = bus_wdata[BIT_FLAG];

  adc_bus_decode u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .ctl_wr(ctl_wr), .res_rd(res_rd), .hit_ctl(hit_ctl), .hit_res(hit_res)
  );

  always_comb begin
    ctl_d.ien  = bus_wdata[BIT_IEN];
    ctl_d.rep  = bus_wdata[BIT_REP];
    ctl_d.chan = bus_wdata[CH_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '{ien: 1'b0, rep: 1'b0, chan: CH_OFF};
    else if (ctl_wr) ctl_q <= ctl_d;
  end

  adc_conv_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .new_chan(ctl_d.chan),
    .rep_mode(ctl_q.rep), .conv_done(conv_done),
    .busy(busy), .start(conv_start), .done_acc(done_acc)
  );

  adc_flag_unit #(.RW(DATA_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .done_acc(done_acc), .result(conv_result),
    .res_rd(res_rd), .ctl_wr(ctl_wr), .ien(ctl_q.ien),
    .flag_q(flag_q), .irq_q(irq_q), .data_q(data_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_ctl) begin
      bus_rdata[BIT_FLAG]   = flag_q & ~ctl_q.ien;
      bus_rdata[BIT_IEN]    = ctl_q.ien;
      bus_rdata[BIT_REP]    = ctl_q.rep;
      bus_rdata[CH_W-1:0]   = ctl_q.chan;
    end else if (hit_res) begin
      bus_rdata = data_q;
    end
  end

  assign conv_chan = ctl_q.chan;
  assign irq       = irq_q;
endmodule

// File: rtl/adc_ctrl_regs_chk.sv
module adc_ctrl_regs_chk
  import adc_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr,
  input logic              res_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              conv_start,
  input logic              conv_done,
  input logic              busy,
  input logic              ien,
  input logic              flag_q,
  input logic              irq,
  input logic [DATA_W-1:0] data_q
);
  p_start_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[CH_W-1:0] != CH_OFF) |=> conv_start);
  p_off_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[CH_W-1:0] == CH_OFF) |=> !conv_start);
  p_irq_cleared_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !irq);
  p_irq_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ien);
  p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(conv_done && busy) || ctl_wr) |=> $stable(data_q));
  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !res_rd) |=> flag_q);
endmodule

bind adc_ctrl_regs adc_ctrl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .res_rd(res_rd),
  .bus_wdata(bus_wdata), .conv_start(conv_start), .conv_done(conv_done),
  .busy(busy), .ien(ctl_q.ien), .flag_q(flag_q), .irq(irq), .data_q(data_q)
);

// File: tb/adc_ctrl_regs_bench.sv
module adc_ctrl_regs_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, bus_wr, bus_rd, conv_done, conv_start, irq;
  logic [7:0] bus_addr, bus_wdata, bus_rdata, conv_result;
  logic [4:0] conv_chan;

  adc_ctrl_regs u_adc_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_result(conv_result), .irq(irq)
  );

  int total = 0, bad = 0;
  string req = "R1";

  // behavioural reference state
  bit m_ien = 0, m_rep = 0, m_flag = 0, m_irq = 0, m_busy = 0, m_start = 0;
  int m_ch = 31, m_data = 0;

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    int exp_rd;
    if (bus_addr == 8'h3C)
      exp_rd = ((m_flag && !m_ien) ? 128 : 0) + (m_ien ? 64 : 0) + (m_rep ? 32 : 0) + m_ch;
    else if (bus_addr == 8'h3D) exp_rd = m_data;
    else exp_rd = 0;
    chk("rdata", int'(bus_rdata), exp_rd);
    chk("irq", int'(irq), int'(m_irq));
    chk("start", int'(conv_start), int'(m_start));
    chk("chan", int'(conv_chan), m_ch);
  endtask

  task automatic model_edge(int a, bit w, bit r, int wd, bit d, int res);
    bit wr_ctl = w && a == 8'h3C;
    bit rd_res = r && a == 8'h3D;
    m_start = 0;
    if (wr_ctl) begin
      m_ien = wd[6]; m_rep = wd[5]; m_ch = wd & 31; m_irq = 0;
      m_busy = (m_ch != 31); m_start = m_busy;
    end else begin
      if (rd_res) begin m_flag = 0; m_irq = 0; end
      if (d && m_busy) begin
        m_data = res;
        if (m_ien) m_irq = 1; else m_flag = 1;
        if (m_rep) m_start = 1; else m_busy = 0;
      end
    end
  endtask

  task automatic step(int a, bit w, bit r, int wd, bit d, int res);
    bus_addr = 8'(a); bus_wr = w; bus_rd = r; bus_wdata = 8'(wd);
    conv_done = d; conv_result = 8'(res);
    @(posedge clk);
    model_edge(a, w, r, wd, d, res);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int a = 8'h3C);       step(a, 0, 0, 0, 0, 0);   endtask
  task automatic wr_ctl(int v);             step(8'h3C, 1, 0, v, 0, 0); endtask
  task automatic rd_res();                  step(8'h3D, 0, 1, 0, 0, 0); endtask
  task automatic done(int res);             step(8'h3C, 0, 0, 0, 1, res); endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; bus_addr = 8'h3C; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    conv_done = 0; conv_result = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    req = "R1"; compare(); idle(8'h3D);
    req = "R2"; wr_ctl(8'hFF); idle(); wr_ctl(8'h83); // bit7 ignored
    req = "R3"; idle(); idle();
    req = "R4"; done(8'hA5); idle(8'h3D);
    req = "R5"; idle(); idle(); idle();
    req = "R9"; idle(); idle();
    req = "R5"; rd_res(); idle();
    req = "R6"; wr_ctl(8'h42); idle(); done(8'h5A); idle(); idle(8'h3D);
    req = "R7"; wr_ctl(8'h42); idle(); done(8'h6B); idle(); rd_res(); idle();
    req = "R8"; wr_ctl(8'h27); idle();
    for (int i = 0; i < 3; i++) begin done(8'h10 + i); idle(8'h3D); idle(); end
    rd_res();
    req = "R10"; step(8'h3C, 1, 0, 8'h04, 1, 8'h99); idle(8'h3D); idle();
    done(8'h33); idle();
    req = "R3"; wr_ctl(8'h08); idle(); wr_ctl(8'h1F); idle();
    req = "R11"; done(8'hEE); idle(8'h3D); idle();
    req = "R12"; rd_res(); wr_ctl(8'h01); idle();
    step(8'h3D, 0, 1, 0, 1, 8'h77); idle(); idle(8'h3D);
    wr_ctl(8'h41); idle(); step(8'h3D, 0, 1, 0, 1, 8'h78); idle();
    req = "R13"; idle(8'h10); idle(8'hFF); idle(8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule